// File: doc/BRIEF.md
# Quasi-Random Test Pattern Generator

This block drives a T1 or E1 line transmitter with a quasi-random test bit stream. In T1 mode it runs a 20-stage maximal-length shift register, which repeats every 2^20-1 bits. It caps zero runs by forcing a one whenever fourteen zeros have already gone out in a row. In E1 mode it runs a 15-stage register, which repeats every 2^15-1 bits. The E1 output is the inverse of the register's bit, and zero runs are left as they are. The generator runs only when the two-bit pattern-select field holds the test-pattern code. For every other code the block stays quiet and holds its registers at their seeds.

Two asynchronous request pins allow manual test actions. A rising edge on the error pin inverts exactly one later output bit. If that bit is being forced to one by the zero-run limit, the inversion moves to the following bit. A rising edge on the violation pin raises a one-bit flag toward the downstream line coder. The line coder turns the flag into a bipolar violation, whichever coding it uses. All logic runs on one clock. A bit-enable strobe marks the cycles that produce a new bit.

Top module: `qrss_gen`

## Requirements
- R1: After a synchronous active-low reset, tx_bit and tx_viol are 0.
- R2: The generator is active only when pat_sel == 2'b10. For any other value, tx_bit and tx_viol read 0 after the next clock and both shift registers return to their seeds. Error or violation requests that arrive while inactive are discarded and have no effect after reactivation.
- R3: T1 mode (e1_mode = 0) uses a 20-bit register s, seeded to 20'h00001. On each produced bit, the raw bit is s[19], and s is then updated to {s[18:0], s[19]^s[16]}.
- R4: E1 mode (e1_mode = 1) uses a 15-bit register s, seeded to 15'h7FFF. On each produced bit, the raw bit is ~s[14], and s is then updated to {s[13:0], s[14]^s[13]}. E1 output has no zero-run limit.
- R5: In T1 mode, a bit produced right after 14 consecutive output zeros is forced to 1. T1 output therefore never holds more than 14 zeros in a row. The run count covers output bits after forcing and after error insertion.
- R6: Each rising edge on err_req inverts exactly one produced bit, provided at least four clocks separate the edge from the next bit_en. Holding err_req high inserts no further errors.
- R7: If an error request is pending when a bit is forced by R5, that bit stays 1 and the inversion is applied to the next produced bit.
- R8: A rising edge on viol_req sets tx_viol to 1 for exactly the next produced bit, in either mode. tx_viol is 0 on the bits after that.
- R9: A change of e1_mode reseeds both registers and clears the zero-run count. The first bit after the change is the first bit of the new mode's sequence.
- R10: tx_bit and tx_viol change only on a clock where bit_en is high or a reseed occurs. Each produced bit appears one clock after its bit_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Strobe that produces one new bit |
| pat_sel | input | 2 | Pattern-select field; 2'b10 enables the generator |
| e1_mode | input | 1 | 0 selects T1 sequence, 1 selects E1 sequence |
| err_req | input | 1 | Asynchronous single-error request, rising edge |
| viol_req | input | 1 | Asynchronous violation request, rising edge |
| tx_bit | output | 1 | Registered test-pattern data bit |
| tx_viol | output | 1 | Registered violation request for the current bit |

## Verification
The assertions assume that pat_sel and e1_mode change only between produced bits, never in the same cycle as bit_en. They also assume that the request pins toggle slowly enough for the synchronizer to see every edge. The bench changes the configuration only at a falling edge with bit_en low and then idles for a clock. It holds each request high for four clocks before the next bit_en, so every pending flag is set before the bit that is expected to carry it.

// File: rtl/qrss_pkg.sv
// Shared constants for the quasi-random test pattern generator.
// Assumes the pattern-select code below is decoded by the top module only.
package qrss_pkg;
    localparam logic [1:0] PAT_QRSS   = 2'b10;
    localparam int         T1_LEN     = 20;
    localparam int         T1_TAP     = 17;
    localparam int         E1_LEN     = 15;
    localparam int         E1_TAP     = 14;
    localparam int         ZERO_LIMIT = 14;
endpackage

// File: rtl/qrss_lfsr.sv
// Fibonacci shift register, shifting toward the MSB with feedback into bit 0.
// raw_o is the MSB before the shift. load has priority over adv.
// Assumes SEED is nonzero.
module qrss_lfsr #(
    parameter int            LEN  = 20,
    parameter int            TAP  = 17,
    parameter logic [LEN-1:0] SEED = LEN'(1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic adv,
    output logic raw_o
);
    logic [LEN-1:0] sr;
    logic           fb;

    // feedback from the top stage and the tap stage
    always_comb fb = sr[LEN-1] ^ sr[TAP-1];

    // seed on reset or load, otherwise shift on advance
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            sr <= SEED;
        else if (adv)
            sr <= {sr[LEN-2:0], fb};
    end

    always_comb raw_o = sr[LEN-1];

    assert_state_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (sr != '0));
endmodule

// File: rtl/qrss_req_sync.sv
// Brings an asynchronous request into the clock domain through STAGES flops.
// Detects the rising edge and holds a pending flag until it is taken or dropped.
// Assumes each request level lasts longer than STAGES+1 clocks.
module qrss_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    input  logic drop,
    input  logic take,
    output logic pend
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              rise;

    generate
        if (STAGES == 1) begin : g_one
            // single-stage capture
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= req_async;
            end
        end else begin : g_multi
            // multi-stage capture chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], req_async};
            end
        end
    endgenerate

    // delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    always_comb rise = chain[STAGES-1] & ~prev;

    // pending flag: drop wins, then a new edge, then consumption
    always_ff @(posedge clk) begin
        if (!rst_n || drop) pend <= 1'b0;
        else if (rise)      pend <= 1'b1;
        else if (take)      pend <= 1'b0;
    end

    assert_take_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && take && !rise && !drop) |=> !pend);
    assert_drop_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !pend);
endmodule

// File: rtl/qrss_gen.sv
// Quasi-random test pattern generator for T1/E1 transmit.
// T1: 20-stage sequence with zero runs capped at 14. E1: 15-stage sequence, inverted.
// Assumes pat_sel and e1_mode change only on cycles where bit_en is low.
module qrss_gen
    import qrss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic [1:0] pat_sel,
    input  logic       e1_mode,
    input  logic       err_req,
    input  logic       viol_req,
    output logic       tx_bit,
    output logic       tx_viol
);
    localparam int ZW = $clog2(ZERO_LIMIT + 2);
    localparam logic [ZW-1:0] ZLIM = ZW'(ZERO_LIMIT);
    localparam logic [ZW-1:0] ZSAT = ZW'(ZERO_LIMIT + 1);

    logic          active, mode_q, reseed, bit_go;
    logic          t1_raw, e1_raw, src, jam, nxt;
    logic          err_pend, viol_pend, err_take, viol_take;
    logic [ZW-1:0] zrun;

    always_comb active = (pat_sel == PAT_QRSS);

    // remember the mode to spot changes
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= e1_mode;
    end

    always_comb reseed = !active || (e1_mode != mode_q);
    always_comb bit_go = bit_en && !reseed;

    qrss_lfsr #(.LEN(T1_LEN), .TAP(T1_TAP), .SEED(T1_LEN'(1))) i_t1 (
        .clk(clk), .rst_n(rst_n), .load(reseed),
        .adv(bit_go && !e1_mode), .raw_o(t1_raw));

    qrss_lfsr #(.LEN(E1_LEN), .TAP(E1_TAP), .SEED({E1_LEN{1'b1}})) i_e1 (
        .clk(clk), .rst_n(rst_n), .load(reseed),
        .adv(bit_go && e1_mode), .raw_o(e1_raw));

    qrss_req_sync #(.STAGES(SYNC_STAGES)) i_err (
        .clk(clk), .rst_n(rst_n), .req_async(err_req),
        .drop(!active), .take(err_take), .pend(err_pend));

    qrss_req_sync #(.STAGES(SYNC_STAGES)) i_viol (
        .clk(clk), .rst_n(rst_n), .req_async(viol_req),
        .drop(!active), .take(viol_take), .pend(viol_pend));

    // choose source bit, apply zero-run forcing and error insertion
    always_comb begin
        src       = e1_mode ? ~e1_raw : t1_raw;
        jam       = !e1_mode && (zrun == ZLIM);
        err_take  = bit_go && err_pend && !jam;
        viol_take = bit_go && viol_pend;
        nxt       = jam ? 1'b1 : (src ^ err_take);
    end

    // count consecutive output zeros, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || reseed) zrun <= '0;
        else if (bit_go)      zrun <= nxt ? '0 : ((zrun == ZSAT) ? zrun : zrun + 1'b1);
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n || reseed) begin
            tx_bit  <= 1'b0;
            tx_viol <= 1'b0;
        end else if (bit_go) begin
            tx_bit  <= nxt;
            tx_viol <= viol_pend;
        end
    end

    assert_jam_forces_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_go && !e1_mode && zrun == ZLIM) |=> tx_bit);
    assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !e1_mode) |-> (zrun <= ZLIM));
    assert_inactive_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!tx_bit && !tx_viol));
    assert_defer_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_go && jam && err_pend) |=> err_pend);
    assert_viol_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_go && viol_pend) |=> tx_viol);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !reseed) |=> ($stable(tx_bit) && $stable(tx_viol)));
endmodule

// File: tb/test_qrss_gen.sv
module test_qrss_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] pat_sel = 2'b00;
    logic       e1_mode = 1'b0;
    logic       err_req = 1'b0;
    logic       viol_req = 1'b0;
    logic       tx_bit, tx_viol;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference state, built from the requirements
    logic [19:0] m_t1;
    logic [14:0] m_e1;
    int          m_zc;
    bit          m_perr, m_pviol, m_active, m_mode;
    int          run_len;

    always #4 clk = ~clk;

    qrss_gen i_qrss_gen (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pat_sel(pat_sel),
        .e1_mode(e1_mode), .err_req(err_req), .viol_req(viol_req),
        .tx_bit(tx_bit), .tx_viol(tx_viol));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic m_seed();
        m_t1 = 20'h00001;
        m_e1 = 15'h7FFF;
        m_zc = 0;
    endtask

    // one produced bit; model and compare (R3 R4 R5 R6 R7 R8 R10)
    task automatic do_bit(input string req);
        bit raw, jam, et, b, v;
        if (m_active) begin
            raw = m_mode ? ~m_e1[14] : m_t1[19];
            jam = !m_mode && (m_zc == 14);
            et  = m_perr && !jam;
            b   = jam ? 1'b1 : (raw ^ et);
            if (et) m_perr = 1'b0;
            v   = m_pviol;
            m_pviol = 1'b0;
            m_zc = b ? 0 : ((m_zc < 15) ? m_zc + 1 : 15);
            if (m_mode) m_e1 = {m_e1[13:0], m_e1[14] ^ m_e1[13]};
            else        m_t1 = {m_t1[18:0], m_t1[19] ^ m_t1[16]};
        end else begin
            b = 1'b0;
            v = 1'b0;
        end
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        chk(tx_bit == b, req, tx_bit, b);
        chk(tx_viol == v, req, tx_viol, v);
        if (m_active && !m_mode) begin
            run_len = tx_bit ? 0 : run_len + 1;
            if (run_len > 14) chk(1'b0, "R5 zero run", run_len, 14);
        end
    endtask

    // idle clocks; outputs must hold (R10)
    task automatic idle(input int n);
        logic b0, v0;
        b0 = tx_bit;
        v0 = tx_viol;
        repeat (n) @(negedge clk);
        chk(tx_bit == b0 && tx_viol == v0, "R10 hold", {tx_bit, tx_viol}, {b0, v0});
    endtask

    task automatic set_cfg(input logic [1:0] sel, input bit mode);
        bit rs;
        rs = (sel != 2'b10) || (mode != m_mode) || !m_active;
        pat_sel = sel;
        e1_mode = mode;
        m_active = (sel == 2'b10);
        m_mode = mode;
        if (rs) m_seed();
        if (!m_active) begin
            m_perr = 1'b0;
            m_pviol = 1'b0;
        end
        run_len = 0;
        @(negedge clk);
        if (rs) chk(!tx_bit && !tx_viol, "R2/R9 reseed clears", {tx_bit, tx_viol}, 0);
    endtask

    task automatic raise_err();
        err_req = 1'b1;
        idle(4);
        err_req = 1'b0;
        if (m_active) m_perr = 1'b1;
        idle(1);
    endtask

    task automatic raise_viol();
        viol_req = 1'b1;
        idle(4);
        viol_req = 1'b0;
        if (m_active) m_pviol = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        m_active = 1'b0; m_mode = 1'b0; m_perr = 1'b0; m_pviol = 1'b0;
        m_seed();
        repeat (3) @(negedge clk);
        chk(tx_bit == 0, "R1 reset bit", tx_bit, 0);
        chk(tx_viol == 0, "R1 reset viol", tx_viol, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_inactive();
        set_cfg(2'b00, 1'b0);
        repeat (4) do_bit("R2 sel 00");
        set_cfg(2'b01, 1'b0);
        repeat (4) do_bit("R2 sel 01");
        set_cfg(2'b11, 1'b0);
        repeat (4) do_bit("R2 sel 11");
    endtask

    // T1 from seed: 14 zeros, forced one with deferred error (R3 R5 R7)
    task automatic t_t1_jam_defer();
        set_cfg(2'b10, 1'b0);
        repeat (14) do_bit("R3 t1 head");
        raise_err();
        do_bit("R5 forced bit");
        chk(tx_bit == 1, "R5 jam to one", tx_bit, 1);
        do_bit("R7 deferred error");
        chk(tx_bit == 1, "R7 error on next bit", tx_bit, 1);
        repeat (400) do_bit("R3 t1 sequence");
    endtask

    task automatic t_err_level();
        raise_err();
        do_bit("R6 single error");
        err_req = 1'b1;
        idle(4);
        if (m_active) m_perr = 1'b1;
        repeat (6) do_bit("R6 held level one error");
        err_req = 1'b0;
        idle(1);
        repeat (20) do_bit("R6 after error");
    endtask

    task automatic t_viol();
        raise_viol();
        do_bit("R8 violation bit");
        chk(tx_viol == 1, "R8 viol set", tx_viol, 1);
        do_bit("R8 violation cleared");
        chk(tx_viol == 0, "R8 viol clear", tx_viol, 0);
    endtask

    // E1: 15 zeros from seed, no forcing (R4 R9)
    task automatic t_e1();
        int zeros;
        set_cfg(2'b10, 1'b1);
        zeros = 0;
        for (int i = 0; i < 15; i++) begin
            do_bit("R4 e1 head");
            if (!tx_bit) zeros++;
        end
        chk(zeros == 15, "R4 no zero limit in E1", zeros, 15);
        repeat (300) do_bit("R4 e1 sequence");
        raise_err();
        raise_viol();
        repeat (20) do_bit("R8 e1 err and viol");
    endtask

    task automatic t_mode_back();
        set_cfg(2'b10, 1'b0);
        repeat (40) do_bit("R9 t1 after mode change");
    endtask

    task automatic t_drop_inactive();
        set_cfg(2'b00, 1'b0);
        raise_err();
        raise_viol();
        set_cfg(2'b10, 1'b0);
        repeat (30) do_bit("R2 requests dropped");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        run_len = 0;
        @(negedge clk);
        t_reset();
        t_inactive();
        t_t1_jam_defer();
        t_err_level();
        t_viol();
        t_e1();
        t_mode_back();
        t_drop_inactive();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule